// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Controller

This block sits next to a processor's program-counter logic and carries out a hardware repeat instruction. The repeat instruction supplies the number of instructions in the block that follows it and the number of passes over that block. The controller stores the first and last addresses of the block. Each time an instruction completes, it checks whether that instruction was the last one in the block. If more passes remain, it asks the next-PC multiplexer to return to the first address. When no passes remain, it lets execution fall through to the next address.

The processor reports each completed instruction with one strobe. With that strobe it gives the instruction's true address and says whether that instruction was a taken branch or a repeat instruction. A taken branch anywhere inside the loop ends the loop, and the branch target always has priority over the loop-back address. A step-stall input holds the controller still, so a single-stepped program goes through the same sequence of addresses as one that runs freely.

Top module: `rep_loop_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rep_active` and `pc_override_valid` are 0.
- R2: A repeat instruction at address P completes with `rep_len` = L, where L is 1 to 511 and is the real instruction count. `rep_active` is 1 on the next cycle, and the block covers addresses P+1 through P+L, taken modulo 2^AW.
- R3: A repeat instruction with `rep_len` = 0 acts exactly as a NOP, whatever `rep_count` holds. It changes no loop state. If it is the last instruction of an active block, the normal loop-back decision applies to it.
- R4: With `rep_count` = N ≥ 1, the block runs N times. A loop-back to P+1 is issued after the last instruction of each of the first N-1 passes. After the Nth pass, `pc_override_valid` stays 0 and `rep_active` falls.
- R5: With `rep_count` = 0, the block repeats without end until a taken branch or a new repeat instruction ends it.
- R6: A completed instruction flagged `branch_taken` clears `rep_active` and `pc_override_valid` on the next cycle. The branch has priority over a loop-back, including on the last or only instruction of a block, and over `rep_start`.
- R7: The outputs are registered. They change only on the cycle after a completed instruction, and they hold between completions. `pc_override` is meaningful only while `pc_override_valid` is 1.
- R8: `pc_override_valid` is never 1 while `rep_active` is 0.
- R9: A repeat instruction with nonzero length that completes while a loop is active replaces that loop's bounds and pass count.
- R10: While `step_stall` is 1, `pc_advance` is ignored and all outputs and loop state hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_advance | input | 1 | One strobe per completed instruction |
| step_stall | input | 1 | Holds all state and ignores `pc_advance` |
| cur_pc | input | AW | True address of the completing instruction |
| rep_start | input | 1 | The completing instruction is a repeat instruction |
| rep_len | input | 9 | Block length in instructions (0 makes the repeat a NOP) |
| rep_count | input | CW | Number of passes (0 means repeat forever) |
| branch_taken | input | 1 | The completing instruction is a taken branch |
| pc_override_valid | output | 1 | Next fetch must use `pc_override` |
| pc_override | output | AW | Loop-back address (block start) |
| rep_active | output | 1 | A repeat loop is in progress |

## Verification
A wrong stored last address shows up at the ports at the end of the first pass: the loop-back pulse either does not appear or appears on the wrong completion. A wrong stored start address shows up the first time a loop-back pulse is issued. A pass counter that is off by one shifts the cycle on which `rep_active` falls by one full block. This appears only at the end of the loop, so the tests use counts of 1, 2 and 3 to expose it quickly. A missed cancel leaves `rep_active` high on the cycle after the branch, and a leak through the stall path changes the outputs during a held cycle.

// File: rtl/rep_loop_pkg.sv
package rep_loop_pkg;

  typedef enum logic [2:0] {
    EV_HOLD,
    EV_STEP,
    EV_CANCEL,
    EV_ARM,
    EV_LOOP,
    EV_EXIT
  } rep_ev_e;

endpackage

// File: rtl/rep_bounds.sv
module rep_bounds #(
  parameter int AW = 20,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [AW-1:0] cur_pc,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] start_addr,
  output logic [AW-1:0] last_addr,
  output logic          at_last
);

  localparam int PADW = AW - LW;

  logic [AW-1:0] len_ext;

  assign len_ext = {{PADW{1'b0}}, len};
  assign at_last = (cur_pc == last_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr <= '0;
      last_addr  <= '0;
    end else if (arm) begin
      start_addr <= cur_pc + AW'(1);
      last_addr  <= cur_pc + len_ext;
    end
  end

  // R2
  bounds_arm_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> (start_addr == $past(cur_pc) + AW'(1)) &&
            (last_addr - start_addr == $past(len_ext) - AW'(1)));

endmodule

// File: rtl/rep_iter.sv
module rep_iter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] count,
  input  logic          dec,
  output logic          more_left
);

  logic [CW-1:0] remaining;
  logic          forever_q;

  assign more_left = forever_q || (remaining > CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      forever_q <= 1'b0;
    end else if (load) begin
      remaining <= count;
      forever_q <= (count == '0);
    end else if (dec && !forever_q) begin
      remaining <= remaining - CW'(1);
    end
  end

  // R4
  iter_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && !forever_q) |=> remaining == $past(remaining) - CW'(1));

  // R5
  iter_forever_chk: assert property (@(posedge clk) disable iff (rst)
    (load && count == '0) |=> forever_q && more_left);

endmodule

// File: rtl/rep_seq.sv
module rep_seq
  import rep_loop_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pc_advance,
  input  logic          step_stall,
  input  logic          rep_start,
  input  logic          len_nz,
  input  logic          branch_taken,
  input  logic          at_last,
  input  logic          more_left,
  input  logic [AW-1:0] start_addr,
  output logic          arm,
  output logic          dec,
  output logic          rep_active,
  output logic          ov_valid,
  output logic [AW-1:0] ov_pc
);

  rep_ev_e ev;
  logic    adv;

  assign adv = pc_advance && !step_stall;

  always_comb begin
    if (!adv)                       ev = EV_HOLD;
    else if (branch_taken)          ev = EV_CANCEL;
    else if (rep_start && len_nz)   ev = EV_ARM;
    else if (rep_active && at_last) ev = more_left ? EV_LOOP : EV_EXIT;
    else                            ev = EV_STEP;
  end

  assign arm = (ev == EV_ARM);
  assign dec = (ev == EV_LOOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_active <= 1'b0;
      ov_valid   <= 1'b0;
      ov_pc      <= '0;
    end else begin
      case (ev)
        EV_HOLD: ;
        EV_STEP: ov_valid <= 1'b0;
        EV_CANCEL, EV_EXIT: begin
          rep_active <= 1'b0;
          ov_valid   <= 1'b0;
        end
        EV_ARM: begin
          rep_active <= 1'b1;
          ov_valid   <= 1'b0;
        end
        EV_LOOP: begin
          ov_valid <= 1'b1;
          ov_pc    <= start_addr;
        end
        default: ov_valid <= 1'b0;
      endcase
    end
  end

  // R8
  ov_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
    ov_valid |-> rep_active);

  // R6
  branch_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && branch_taken) |=> !rep_active && !ov_valid);

  // R3
  len0_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && rep_start && !len_nz && !branch_taken && !rep_active) |=> !rep_active && !ov_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(rep_active) && $stable(ov_valid) && $stable(ov_pc));

  // R2
  arm_active_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> rep_active && !ov_valid);

endmodule

// File: rtl/rep_loop_ctrl.sv
module rep_loop_ctrl #(
  parameter int AW = 20,
  parameter int LW = 9,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pc_advance,
  input  logic          step_stall,
  input  logic [AW-1:0] cur_pc,
  input  logic          rep_start,
  input  logic [LW-1:0] rep_len,
  input  logic [CW-1:0] rep_count,
  input  logic          branch_taken,
  output logic          pc_override_valid,
  output logic [AW-1:0] pc_override,
  output logic          rep_active
);

  logic          arm, dec, at_last, more_left, len_nz;
  logic [AW-1:0] start_addr, last_addr;

  assign len_nz = (rep_len != '0);

  rep_bounds #(.AW(AW), .LW(LW)) u_bounds (
    .clk(clk), .rst(rst), .arm(arm), .cur_pc(cur_pc), .len(rep_len),
    .start_addr(start_addr), .last_addr(last_addr), .at_last(at_last)
  );

  rep_iter #(.CW(CW)) u_iter (
    .clk(clk), .rst(rst), .load(arm), .count(rep_count), .dec(dec),
    .more_left(more_left)
  );

  rep_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .pc_advance(pc_advance), .step_stall(step_stall),
    .rep_start(rep_start), .len_nz(len_nz), .branch_taken(branch_taken),
    .at_last(at_last), .more_left(more_left), .start_addr(start_addr),
    .arm(arm), .dec(dec), .rep_active(rep_active),
    .ov_valid(pc_override_valid), .ov_pc(pc_override)
  );

  // R4
  loop_target_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pc_override_valid) |-> pc_override == start_addr);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> !rep_active && !pc_override_valid);

endmodule

// File: tb/rep_loop_ctrl_tb.sv
module rep_loop_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pc_advance = 0, step_stall = 0, rep_start = 0, branch_taken = 0;
  logic [8:0] rep_len = '0;
  logic [CW-1:0] rep_count = '0;
  logic [AW-1:0] cur_pc = '0;
  logic pc_override_valid, rep_active;
  logic [AW-1:0] pc_override;

  always #(CLK_PERIOD/2) clk = ~clk;

  rep_loop_ctrl #(.AW(AW), .LW(9), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .pc_advance(pc_advance), .step_stall(step_stall),
    .cur_pc(cur_pc), .rep_start(rep_start), .rep_len(rep_len),
    .rep_count(rep_count), .branch_taken(branch_taken),
    .pc_override_valid(pc_override_valid), .pc_override(pc_override),
    .rep_active(rep_active)
  );

  int vectors = 0, fails = 0;
  bit m_act = 0, m_ov = 0, m_inf = 0;
  logic [AW-1:0] m_ovpc = '0, m_start = '0, m_last = '0, pc = '0;
  logic [CW-1:0] m_rem = '0;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic model(input bit st, input bit [8:0] l, input bit [CW-1:0] c,
                       input bit br, input bit adv);
    if (!adv) return;
    if (br) begin m_act = 0; m_ov = 0; end
    else if (st && l != 0) begin
      m_act = 1; m_ov = 0; m_start = pc + 1; m_last = pc + AW'(l);
      m_inf = (c == 0); m_rem = c;
    end else if (m_act && pc == m_last) begin
      if (m_inf || m_rem > 1) begin
        m_ov = 1; m_ovpc = m_start;
        if (!m_inf) m_rem = m_rem - 1;
      end else begin m_act = 0; m_ov = 0; end
    end else m_ov = 0;
  endtask

  task automatic step(input bit st, input bit [8:0] l, input bit [CW-1:0] c,
                      input bit br, input logic [AW-1:0] tgt, input bit adv,
                      input bit stl, input string tag);
    bit eff;
    @(negedge clk);
    pc_advance = adv; step_stall = stl; rep_start = st; rep_len = l;
    rep_count = c; branch_taken = br; cur_pc = pc;
    eff = adv && !stl;
    model(st, l, c, br, eff);
    @(posedge clk); #1;
    check({tag, " rep_active"}, 64'(rep_active), 64'(m_act));
    check({tag, " override_valid"}, 64'(pc_override_valid), 64'(m_ov));
    check({tag, " R8 valid without active"}, 64'(pc_override_valid && !rep_active), 64'(0));
    if (m_ov) check({tag, " override_pc"}, 64'(pc_override), 64'(m_ovpc));
    if (eff) pc = br ? tgt : (m_ov ? m_ovpc : pc + 1);
  endtask

  task automatic adv1(input string tag);
    step(0, 0, 0, 0, 0, 1, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 reset active", 64'(rep_active), 0);
    check("R1 reset override", 64'(pc_override_valid), 0);

    // R3: zero length repeat is a NOP, no skip
    pc = 10;
    step(1, 0, 5, 0, 0, 1, 0, "R3 len0");
    check("R3 len0 next pc", 64'(pc), 64'd11);

    // R2/R4: three passes over 21..22
    pc = 20; seen = 0;
    step(1, 2, 3, 0, 0, 1, 0, "R2 arm");
    check("R2 active after arm", 64'(rep_active), 1);
    for (int i = 0; i < 6; i++) begin
      adv1("R4 pass");
      if (pc_override_valid) seen++;
    end
    check("R4 loopbacks for count 3", 64'(seen), 64'd2);
    check("R4 fall through pc", 64'(pc), 64'd23);
    check("R4 inactive after last pass", 64'(rep_active), 0);

    // R5 forever single-instruction block, then R6 branch on that instruction
    pc = 40;
    step(1, 1, 0, 0, 0, 1, 0, "R5 arm");
    for (int i = 0; i < 25; i++) adv1("R5 forever");
    check("R5 still looping pc", 64'(pc), 64'd41);
    check("R5 still active", 64'(rep_active), 1);
    // R7: outputs hold with no advance
    step(0, 0, 0, 0, 0, 0, 0, "R7 hold");
    check("R7 override held", 64'(pc_override_valid), 1);
    step(0, 0, 0, 1, 100, 1, 0, "R6 branch last");
    check("R6 branch target wins", 64'(pc), 64'd100);
    check("R6 cancelled", 64'(rep_active), 0);

    // R6: branch as only instruction right after arm
    pc = 50;
    step(1, 1, 4, 0, 0, 1, 0, "R6 arm");
    step(0, 0, 0, 1, 60, 1, 0, "R6 one-instr branch");
    check("R6 one-instr no override", 64'(pc_override_valid), 0);

    // R9: new repeat inside active loop
    pc = 70;
    step(1, 3, 0, 0, 0, 1, 0, "R9 outer");
    adv1("R9 body");
    step(1, 2, 2, 0, 0, 1, 0, "R9 inner");
    for (int i = 0; i < 4; i++) adv1("R9 inner pass");
    check("R9 replaced loop exits", 64'(pc), 64'd75);
    check("R9 inactive", 64'(rep_active), 0);

    // R10: stall freezes
    pc = 80;
    step(1, 1, 2, 0, 0, 1, 0, "R10 arm");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, 1, "R10 stalled");
    check("R10 no loopback while stalled", 64'(pc_override_valid), 0);
    adv1("R10 release");
    check("R10 loopback after release", 64'(pc_override_valid), 1);

    // R3: zero-length repeat as last block instruction still loops back
    pc = 90;
    step(1, 2, 2, 0, 0, 1, 0, "R3 arm");
    adv1("R3 body");
    step(1, 0, 7, 0, 0, 1, 0, "R3 len0 last");
    check("R3 loopback from nop", 64'(pc), 64'd91);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit stl = ($urandom_range(0, 9) == 0);
      bit adv = ($urandom_range(0, 9) != 0);
      if (r < 5)
        step(1, 9'($urandom_range(0, 6)), CW'($urandom_range(0, 4)), 0, 0, adv, stl, "R2 rand arm");
      else if (r < 10)
        step(0, 0, 0, 1, AW'($urandom_range(0, 300)), adv, stl, "R6 rand branch");
      else
        step(0, 0, 0, 0, 0, adv, stl, "R4 rand step");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule